// File: doc/BRIEF.md
# Program Fetch Source Selector

This block sits between the instruction fetch unit and the two places program bytes can come from: an on-chip program ROM and an external program bus. For every fetch strobe it looks at the 16-bit fetch address and at an external-access pin level. It then either reads the on-chip array or raises a request on the external bus. Whichever source serves the fetch, the byte comes back on a single fetch-data output.

The pin level is captured while reset is asserted and is frozen once reset is released. With the pin low, every fetch goes out on the bus, even at address zero. With the pin high, addresses below the on-chip size are served internally. Addresses at or above that size go to the external bus automatically. Software therefore crosses the boundary by plain sequential execution or by a jump, with no mode switch.

The on-chip size is a parameter, with a minimum of 2 KB. A byte-wide load port fills the array before use. A status output tells which source served the most recent fetch.

Top module: `prog_fetch_sel`

## Requirements
- R1: When the captured pin level is low, every accepted fetch raises `ext_req` on the following cycle, whatever the address, and `served_ext` reads 1.
- R2: When the captured pin level is high and the address is below INT_BYTES, `fetch_valid` is high exactly one cycle after the strobe. `fetch_data` then equals the byte loaded at that address, and `ext_req` stays low.
- R3: When the captured pin level is high and the address is at or above INT_BYTES, the fetch goes to the external bus, and `ext_addr` carries the full 16-bit fetch address.
- R4: `ext_pin` is sampled on every clock edge while `rst_n` is low. Changes on `ext_pin` after reset release do not affect where fetches are served.
- R5: `ext_req` and `busy` stay high, and `ext_addr` stays stable, until `ext_ack` is sampled high. `fetch_valid` rises one cycle after that acknowledge, with `fetch_data` equal to the `ext_data` presented alongside it.
- R6: A fetch strobe that arrives while `busy` is high is ignored: it produces no result and no bus request.
- R7: `served_ext` is 1 when the most recently accepted fetch went to the external bus and 0 when it was served internally. It is 0 after reset.
- R8: Address INT_BYTES-1 is served internally and address INT_BYTES externally. This holds the same way for a sequential walk across the boundary and for jumps in either direction.
- R9: After reset, `fetch_valid`, `ext_req` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | External-access pin level, captured during reset |
| fetch_req | input | 1 | Fetch strobe |
| fetch_addr | input | ADDR_W | Program counter address of the fetch |
| fetch_valid | output | 1 | Fetch data is valid this cycle |
| fetch_data | output | DATA_W | Fetched byte |
| busy | output | 1 | External fetch outstanding; strobes are ignored |
| served_ext | output | 1 | Source of the last accepted fetch (1 = external) |
| ext_req | output | 1 | External bus request |
| ext_addr | output | ADDR_W | External bus address |
| ext_ack | input | 1 | External bus acknowledge |
| ext_data | input | DATA_W | External bus read data |
| load_en | input | 1 | On-chip array write enable |
| load_addr | input | $clog2(INT_BYTES) | On-chip array write address |
| load_data | input | DATA_W | On-chip array write data |

## Verification
An internal fetch produces its result one clock after the edge that takes the strobe. The bench checks `fetch_valid` at the falling edge straight after that edge, with no slack. An external fetch raises `ext_req` one clock after the strobe. The result then appears one clock after the edge that samples the acknowledge. The bench's bus responder drives `ext_ack` at a falling edge and expects the data on the next falling edge. All outputs are sampled on falling edges, and a scoreboard queue holds one expected item per accepted fetch. Any extra result, or any item still left in the queue at the end, is reported.

// File: rtl/prog_fetch_sel.sv
module prog_fetch_sel #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ext_pin,
  input  logic                         fetch_req,
  input  logic [ADDR_W-1:0]            fetch_addr,
  output logic                         fetch_valid,
  output logic [DATA_W-1:0]            fetch_data,
  output logic                         busy,
  output logic                         served_ext,
  output logic                         ext_req,
  output logic [ADDR_W-1:0]            ext_addr,
  input  logic                         ext_ack,
  input  logic [DATA_W-1:0]            ext_data,
  input  logic                         load_en,
  input  logic [$clog2(INT_BYTES)-1:0] load_addr,
  input  logic [DATA_W-1:0]            load_data
);
  localparam int SPACE   = 2 ** ADDR_W;
  localparam int INT_AW  = $clog2(INT_BYTES);
  localparam bit ALL_INT = INT_BYTES >= SPACE;

  logic              pin_q, pend_q, valid_q, src_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rom [INT_BYTES];
  logic              in_range;

  generate
    if (ALL_INT) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = fetch_addr < ADDR_W'(INT_BYTES);
    end
  endgenerate

  wire take   = fetch_req && !pend_q;
  wire go_int = pin_q && in_range;

  always_ff @(posedge clk)
    if (load_en) rom[load_addr] <= load_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= ext_pin;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      src_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (take) begin
        src_q  <= !go_int;
        addr_q <= fetch_addr;
        if (go_int) begin
          data_q  <= rom[fetch_addr[INT_AW-1:0]];
          valid_q <= 1'b1;
        end else begin
          pend_q <= 1'b1;
        end
      end else if (pend_q && ext_ack) begin
        data_q  <= ext_data;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end
    end
  end

  assign fetch_valid = valid_q;
  assign fetch_data  = data_q;
  assign busy        = pend_q;
  assign ext_req     = pend_q;
  assign ext_addr    = addr_q;
  assign served_ext  = src_q;

  // R1
  ext_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !busy && !pin_q |=> ext_req && served_ext);

  // R2
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !busy && pin_q && in_range |=> fetch_valid && !ext_req && !served_ext);

  // R3
  beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !busy && pin_q && !in_range |=> ext_req && ext_addr == $past(fetch_addr));

  // R4
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pin_q));

  // R5
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && !fetch_valid);

  // R5
  ext_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack |=> fetch_valid && !busy && fetch_data == $past(ext_data));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fetch_req && !ext_ack |=> $stable(ext_addr) && $stable(served_ext));
endmodule

// File: tb/sim_prog_fetch_sel.sv
module sim_prog_fetch_sel;
  localparam int INT_BYTES = 2048;

  logic        clk = 0, rst_n = 0, ext_pin = 1, fetch_req = 0;
  logic [15:0] fetch_addr = 0;
  logic        fetch_valid, busy, served_ext, ext_req;
  logic [7:0]  fetch_data, ext_data;
  logic [15:0] ext_addr;
  logic        ext_ack;
  logic        load_en = 0;
  logic [10:0] load_addr = 0;
  logic [7:0]  load_data = 0;

  int checks = 0, fails = 0, wait_cnt = 0;
  bit done = 0;
  logic [8:0] sb[$];

  always #5 clk = ~clk;

  prog_fetch_sel #(.INT_BYTES(INT_BYTES)) u0 (
    .clk, .rst_n, .ext_pin, .fetch_req, .fetch_addr, .fetch_valid, .fetch_data,
    .busy, .served_ext, .ext_req, .ext_addr, .ext_ack, .ext_data,
    .load_en, .load_addr, .load_data);

  function automatic logic [7:0] rom_val(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  function automatic logic [7:0] ext_mem(input logic [15:0] a);
    return a[15:8] + a[7:0] + 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external bus responder: latency 0..3 cycles from ext_addr[1:0]
  initial begin
    ext_ack = 0; ext_data = 0;
    forever begin
      @(negedge clk);
      if (ext_ack) ext_ack = 0;
      else if (ext_req) begin
        if (wait_cnt == int'(ext_addr[1:0])) begin
          ext_ack = 1; ext_data = ext_mem(ext_addr); wait_cnt = 0;
        end else begin
          chk(busy && !fetch_valid, "R5 busy held", busy, 1);
          wait_cnt++;
        end
      end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && fetch_valid) begin
      if (sb.size() == 0) chk(0, "R6 unexpected result", fetch_data, 0);
      else begin
        logic [8:0] e;
        e = sb.pop_front();
        chk(fetch_data == e[7:0], "R2/R3/R5 data", fetch_data, e[7:0]);
        chk(served_ext == e[8], "R7 source", served_ext, e[8]);
      end
    end
  end

  task automatic do_reset(input bit pin);
    rst_n = 0; ext_pin = pin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!fetch_valid && !ext_req && !busy, "R9 reset outputs", {fetch_valid, ext_req, busy}, 0);
    chk(!served_ext, "R7 reset source", served_ext, 0);
  endtask

  task automatic do_fetch(input logic [15:0] a, input bit pin_hi);
    bit ext;
    ext = !pin_hi || a >= 16'(INT_BYTES);
    sb.push_back({ext, ext ? ext_mem(a) : rom_val(a)});
    while (busy) @(negedge clk);
    fetch_req = 1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 0;
    if (!ext) chk(fetch_valid && !ext_req, "R2 one-cycle internal", fetch_valid, 1);
    else begin
      chk(ext_req, "R1/R3 ext request", ext_req, 1);
      chk(ext_addr == a, "R3 ext address", ext_addr, a);
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < INT_BYTES; i++) begin
      load_en = 1; load_addr = 11'(i); load_data = rom_val(16'(i));
      @(negedge clk);
    end
    load_en = 0;

    do_reset(1);
    do_fetch(16'h0000, 1);
    do_fetch(16'h0123, 1);
    do_fetch(16'h1234, 1);   // R3
    do_fetch(16'hFFFF, 1);   // R3
    for (int a = 16'h07FC; a <= 16'h0803; a++) do_fetch(16'(a), 1); // R8 walk
    do_fetch(16'h0900, 1);   // R8 jump out
    do_fetch(16'h0005, 1);   // R8 jump back
    do_fetch(16'h07FF, 1);   // R8
    do_fetch(16'h0800, 1);   // R8

    // R6: strobe during busy is ignored
    sb.push_back({1'b1, ext_mem(16'h2003)});
    fetch_req = 1; fetch_addr = 16'h2003;
    @(negedge clk);
    fetch_addr = 16'h0010;
    @(negedge clk);
    fetch_req = 0;
    chk(ext_addr == 16'h2003, "R6 address kept", ext_addr, 16'h2003);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6 no extra result", sb.size(), 0);

    // R4: pin change after reset ignored
    ext_pin = 0;
    do_fetch(16'h0042, 1);
    do_reset(0);
    ext_pin = 1;
    do_fetch(16'h0000, 0);   // R1
    do_fetch(16'h0456, 0);   // R1
    do_fetch(16'h8001, 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2/R5 all results returned", sb.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule